// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block watches a processor's periodic kick signal and reports when the kicks stop following a healthy rhythm. Only falling edges on the kick input count. Each edge is measured against a window that starts when the watchdog is armed. Edges that come too soon are tallied. Once the tally passes its tolerance, a fault is raised. If no acceptable edge arrives before the long limit runs out, a fault is also raised. The fault output is active low and drives an interrupt or reset path elsewhere in the chip.

The short limit is a single clock-count parameter. The long limit is sixteen times the short one. Every fault is held for a fixed width of one eighth of the long limit, and kicks are disregarded during that time. The window then re-arms from a clean state. If the processor never kicks, the output settles into a steady train of long high phases and short low pulses. The kick input may be asynchronous. It passes through a synchronising chain before any edge detection.

Top module: `wdt_window`

## Requirements
- R1: During and after reset the fault output `wdo_n` is high, the synchroniser holds an idle-high level, and the first window counts from the cycle reset is released. With no kicks, `wdo_n` first falls 16·FAST_CYCLES cycles after release.
- R2: A rising edge on `kick_n` has no effect. A falling edge that arrives during a fault, even when the input then stays low, does not restart a window.
- R3: A falling edge detected when the window count is at least FAST_CYCLES and at most 16·FAST_CYCLES−1 is a valid kick and restarts the window from zero. Kicks with any period P from FAST_CYCLES+1 to 16·FAST_CYCLES keep `wdo_n` high.
- R4: If 16·FAST_CYCLES cycles pass after a window starts with no valid kick, `wdo_n` goes low on the following cycle.
- R5: The third falling edge detected while the window count is below FAST_CYCLES drives `wdo_n` low. The fault shows after the second clock edge that follows the first edge sampling `kick_n` low.
- R6: Each fault holds `wdo_n` low for exactly 2·FAST_CYCLES cycles, which is one eighth of the long limit.
- R7: Falling edges on `kick_n` while `wdo_n` is low neither shorten the fault nor carry into the next window.
- R8: When `wdo_n` returns high, a new window starts with its cycle count and its early-edge tally both at zero.
- R9: With `kick_n` held high, `wdo_n` repeats a cycle of 16·FAST_CYCLES cycles high followed by 2·FAST_CYCLES cycles low.
- R10: One or two early falling edges in a window neither raise a fault nor restart the window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all state |
| rst_n | input | 1 | Synchronous active-low reset |
| kick_n | input | 1 | Kick from the processor; falling edges are events; may be asynchronous |
| wdo_n | output | 1 | Active-low fault flag; high while the window is being watched |

## Verification
A window counter that restarts at the wrong time moves the next fault edge away from its expected cycle. This shows at `wdo_n` within one long window, at most 16·FAST_CYCLES cycles later. A stale early-edge tally, or kicks leaking through during a fault, give a fault three cycles after a kick that should have been harmless, or a low pulse of the wrong length. The bench therefore places every kick at an exact offset from the observed rise of `wdo_n`. It checks the exact cycle of the next fall, and it sweeps the full range of legal kick periods, including both limits.

// File: rtl/wdt_pkg.sv
// Shared definitions for the windowed watchdog.
// Assumes the short limit is given in clock cycles. The long limit and the
// fault width come from it by fixed shifts.
package wdt_pkg;

    // Controller state: watching the window, or holding the fault low
    typedef enum logic {
        WDT_WATCH = 1'b0,
        WDT_TRIP  = 1'b1
    } wdt_state_e;

    // Long limit: sixteen short periods
    function automatic int unsigned slow_of(input int unsigned fast);
        return fast << 4;
    endfunction

    // Fault width: one eighth of the long limit, which is two short periods
    function automatic int unsigned trip_of(input int unsigned fast);
        return fast << 1;
    endfunction

endpackage

// File: rtl/wdt_kick_sync.sv
// Kick input conditioning: a chain of STAGES flops followed by a falling-edge
// detector. Assumes STAGES >= 2. The chain resets to the idle-high level, so
// leaving reset never produces a false edge. fall_o is a one-cycle pulse.
module wdt_kick_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick_n_i,
    output logic fall_o
);

    logic [STAGES-1:0] chain_q;
    logic              last_q;

    // Shift the raw kick through the synchronising chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], kick_n_i};
        end
    end

    // Hold the previous synchronised level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= 1'b1;
        end else begin
            last_q <= chain_q[STAGES-1];
        end
    end

    // High-to-low transition of the synchronised kick
    always_comb begin
        fall_o = last_q & ~chain_q[STAGES-1];
    end

endmodule

// File: rtl/wdt_window_timer.sv
// Window cycle counter. It counts up while run_i is high and holds at LAST,
// where expire_o is raised. It clears when run_i is low or restart_i pulses.
// Assumes LAST fits in CNT_W bits.
module wdt_window_timer #(
    parameter int unsigned CNT_W = 7,
    parameter int unsigned LAST  = 127
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             restart_i,
    output logic [CNT_W-1:0] count_o,
    output logic             expire_o
);

    logic [CNT_W-1:0] count_q;

    // Advance, restart or hold the window count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (!run_i || restart_i) begin
            count_q <= '0;
        end else if (!expire_o) begin
            count_q <= count_q + 1'b1;
        end
    end

    // Expose the count and flag the final window cycle
    always_comb begin
        count_o  = count_q;
        expire_o = (count_q == CNT_W'(LAST));
    end

endmodule

// File: rtl/wdt_early_count.sv
// Tally of early kick edges within one window. It saturates at LIMIT, and
// full_o marks that the next early edge is one too many. clr_i takes
// priority over inc_i.
module wdt_early_count #(
    parameter int unsigned LIMIT = 2,
    parameter int unsigned W     = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] count_o,
    output logic         full_o
);

    logic [W-1:0] count_q;

    // Clear on a new window, otherwise count early edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clr_i) begin
            count_q <= '0;
        end else if (inc_i && !full_o) begin
            count_q <= count_q + 1'b1;
        end
    end

    // Report the tally and whether the tolerance is used up
    always_comb begin
        count_o = count_q;
        full_o  = (count_q == W'(LIMIT));
    end

endmodule

// File: rtl/wdt_trip_timer.sv
// Fault hold timer. It counts the cycles the fault output has been low and
// raises done_o on the last one. It rests at zero while inactive.
module wdt_trip_timer #(
    parameter int unsigned W    = 4,
    parameter int unsigned LAST = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         active_i,
    output logic [W-1:0] count_o,
    output logic         done_o
);

    logic [W-1:0] count_q;

    // Count fault cycles while the fault is held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (!active_i) begin
            count_q <= '0;
        end else if (!done_o) begin
            count_q <= count_q + 1'b1;
        end
    end

    // Expose the count and flag the last fault cycle
    always_comb begin
        count_o = count_q;
        done_o  = (count_q == W'(LAST));
    end

endmodule

// File: rtl/wdt_window.sv
// Windowed watchdog top. It synchronises the kick input and classifies each
// falling edge as early (window count below FAST_CYCLES) or valid. A valid
// edge restarts the window. Edges past the early tolerance, or a window that
// runs out, move the controller to the fault state. The fault is held for a
// fixed width, and kicks are ignored meanwhile.
// Assumes FAST_CYCLES >= 4 and SYNC_STAGES >= 2.
module wdt_window
    import wdt_pkg::*;
#(
    parameter int unsigned FAST_CYCLES = 8,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned EARLY_LIMIT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick_n,
    output logic wdo_n
);

    localparam int unsigned SLOW_T  = slow_of(FAST_CYCLES);
    localparam int unsigned TRIP_T  = trip_of(FAST_CYCLES);
    localparam int unsigned CNT_W   = $clog2(SLOW_T);
    localparam int unsigned TRIP_W  = $clog2(TRIP_T);
    localparam int unsigned EARLY_W = $clog2(EARLY_LIMIT + 1);

    wdt_state_e          state_q;
    wdt_state_e          state_d;
    logic                kick_fall;
    logic [CNT_W-1:0]    win_cnt;
    logic                win_expire;
    logic [EARLY_W-1:0]  early_cnt;
    logic                early_full;
    logic [TRIP_W-1:0]   trip_cnt;
    logic                trip_done;
    logic                watching;
    logic                in_fast;
    logic                early_fall;
    logic                valid_fall;
    logic                trip;

    wdt_kick_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .kick_n_i (kick_n),
        .fall_o   (kick_fall)
    );

    wdt_window_timer #(
        .CNT_W (CNT_W),
        .LAST  (SLOW_T - 1)
    ) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (watching),
        .restart_i (valid_fall),
        .count_o   (win_cnt),
        .expire_o  (win_expire)
    );

    wdt_early_count #(
        .LIMIT (EARLY_LIMIT),
        .W     (EARLY_W)
    ) u_early (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (!watching || valid_fall),
        .inc_i   (early_fall),
        .count_o (early_cnt),
        .full_o  (early_full)
    );

    wdt_trip_timer #(
        .W    (TRIP_W),
        .LAST (TRIP_T - 1)
    ) u_trip (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (!watching),
        .count_o  (trip_cnt),
        .done_o   (trip_done)
    );

    // Classify the current kick edge against the window
    always_comb begin
        watching   = (state_q == WDT_WATCH);
        in_fast    = (win_cnt < CNT_W'(FAST_CYCLES));
        early_fall = watching && kick_fall && in_fast;
        valid_fall = watching && kick_fall && !in_fast;
        trip       = (early_fall && early_full) ||
                     (watching && !kick_fall && win_expire);
    end

    // Next-state choice between watching and fault hold
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WDT_WATCH: if (trip)      state_d = WDT_TRIP;
            WDT_TRIP:  if (trip_done) state_d = WDT_WATCH;
            default:                  state_d = WDT_WATCH;
        endcase
    end

    // Controller state register, reset to watching
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WDT_WATCH;
        end else begin
            state_q <= state_d;
        end
    end

    // Fault output follows the state register directly
    assign wdo_n = watching;

endmodule

// File: rtl/wdt_window_chk.sv
// Property checker for wdt_window, attached by bind. It observes the fault
// output together with the internal window, tally and fault counters.
module wdt_window_chk #(
    parameter int unsigned FAST_CYCLES = 8,
    parameter int unsigned EARLY_LIMIT = 2
) (
    input logic                                      clk,
    input logic                                      rst_n,
    input logic                                      wdo_n,
    input logic                                      kick_fall,
    input logic [$clog2(FAST_CYCLES*16)-1:0]         win_cnt,
    input logic [$clog2(EARLY_LIMIT+1)-1:0]          early_cnt,
    input logic [$clog2(FAST_CYCLES*2)-1:0]          trip_cnt
);

    localparam int unsigned SLOW_T = FAST_CYCLES * 16;
    localparam int unsigned TRIP_T = FAST_CYCLES * 2;
    localparam int unsigned CNT_W  = $clog2(SLOW_T);
    localparam int unsigned TRIP_W = $clog2(TRIP_T);
    localparam int unsigned EW     = $clog2(EARLY_LIMIT + 1);
    localparam int unsigned LR_W   = $clog2(TRIP_T + 1) + 1;

    logic [LR_W-1:0] low_run;

    // Independent count of consecutive low cycles on the fault output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_run <= '0;
        end else if (!wdo_n) begin
            low_run <= low_run + 1'b1;
        end else begin
            low_run <= '0;
        end
    end

    // R3
    valid_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wdo_n && kick_fall && win_cnt >= CNT_W'(FAST_CYCLES))
        |=> (wdo_n && win_cnt == '0));

    // R4
    slow_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wdo_n && !kick_fall && win_cnt == CNT_W'(SLOW_T - 1)) |=> !wdo_n);

    // R5
    third_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wdo_n && kick_fall && win_cnt < CNT_W'(FAST_CYCLES)
         && early_cnt == EW'(EARLY_LIMIT)) |=> !wdo_n);

    // R6
    fault_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdo_n) |-> (low_run == LR_W'(TRIP_T)));

    // R7
    fault_kick_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wdo_n && kick_fall && trip_cnt != TRIP_W'(TRIP_T - 1)) |=> !wdo_n);

    // R8
    fresh_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdo_n) |-> (win_cnt == '0 && early_cnt == '0));

    // R10
    early_tolerated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wdo_n && kick_fall && win_cnt < CNT_W'(FAST_CYCLES)
         && early_cnt < EW'(EARLY_LIMIT))
        |=> (wdo_n && win_cnt == CNT_W'($past(win_cnt) + 1'b1)));

endmodule

bind wdt_window wdt_window_chk #(
    .FAST_CYCLES (FAST_CYCLES),
    .EARLY_LIMIT (EARLY_LIMIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wdo_n     (wdo_n),
    .kick_fall (kick_fall),
    .win_cnt   (win_cnt),
    .early_cnt (early_cnt),
    .trip_cnt  (trip_cnt)
);

// File: tb/sim_wdt_window.sv
// Bench for wdt_window. All stimulus and sampling happen at falling clock
// edges in one process. Kicks are placed at exact offsets from the observed
// rise of wdo_n. A kick driven at the sample taken d cycles after the rise
// is seen by the window with count 2+d.
module sim_wdt_window;

    localparam int FAST = 8;
    localparam int SLOW = FAST * 16;
    localparam int FLT  = SLOW / 8;

    logic clk    = 1'b0;
    logic rst_n  = 1'b0;
    logic kick_n = 1'b1;
    logic wdo_n;

    int cyc   = 0;
    int lows  = 0;
    int t0    = 0;
    int tf    = 0;
    int nchk  = 0;
    int nfail = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    wdt_window #(.FAST_CYCLES(FAST)) u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .kick_n (kick_n),
        .wdo_n  (wdo_n)
    );

    task automatic step();
        @(negedge clk);
        cyc++;
        if (!wdo_n) lows++;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d (sample %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic run_to(input int t);
        while (cyc < t) step();
    endtask

    task automatic kick_at(input int t);
        run_to(t);
        kick_n = 1'b0;
        step();
        kick_n = 1'b1;
    endtask

    // Expect wdo_n high from the window start up to t-1, then low at t
    task automatic fall_at(input int t, input string req);
        run_to(t - 1);
        check(wdo_n && lows == 0, req, lows + (wdo_n ? 0 : 1), 0);
        step();
        check(!wdo_n, req, int'(wdo_n), 0);
        tf = cyc;
    endtask

    task automatic wait_rise();
        while (wdo_n) step();
        while (!wdo_n) step();
        t0   = cyc;
        lows = 0;
    endtask

    initial begin
        // R1: reset level, then first window counted from release
        repeat (3) step();
        check(wdo_n == 1'b1, "R1", int'(wdo_n), 1);
        rst_n = 1'b1;
        t0    = cyc;
        lows  = 0;
        fall_at(t0 + SLOW, "R1");

        // R6 / R9: free-running pulse train
        for (int i = 0; i < 3; i++) begin
            wait_rise();
            check(t0 - tf == FLT, "R6", t0 - tf, FLT);
            fall_at(t0 + SLOW, "R9");
        end

        // R5: three early edges trip the fault two edges after capture
        wait_rise();
        kick_at(t0); kick_at(t0 + 2); kick_at(t0 + 4);
        fall_at(t0 + 7, "R5");

        // R10: two early edges are tolerated and do not restart
        wait_rise();
        kick_at(t0); kick_at(t0 + 2);
        fall_at(t0 + SLOW, "R10");

        // R8: tally from the previous window is gone after the fault
        wait_rise();
        kick_at(t0);
        fall_at(t0 + SLOW, "R8");

        // R5 boundary: third edge at window count FAST-1 still counts as early
        wait_rise();
        kick_at(t0); kick_at(t0 + 2); kick_at(t0 + FAST - 3);
        fall_at(t0 + FAST, "R5");

        // R3 boundary: third edge at window count FAST is valid and restarts
        wait_rise();
        kick_at(t0); kick_at(t0 + 2); kick_at(t0 + FAST - 2);
        fall_at(t0 + FAST + 1 + SLOW, "R3");

        // R7: kicks during the fault are ignored
        begin
            int tstart;
            tstart = tf;
            for (int k = 0; k <= FLT - 6; k += 2) kick_at(tstart + k);
            wait_rise();
            check(t0 - tstart == FLT, "R7", t0 - tstart, FLT);
            fall_at(t0 + SLOW, "R7");
        end

        // R2: a fall during the fault and a later rise have no effect
        run_to(tf + 1);
        kick_n = 1'b0;
        wait_rise();
        run_to(t0 + FAST + 5);
        kick_n = 1'b1;
        fall_at(t0 + SLOW, "R2");

        // R3: sweep every legal kick period, both limits included
        for (int p = FAST + 1; p <= SLOW; p++) begin
            int t;
            int last;
            wait_rise();
            t    = t0 + p - 3;
            last = t;
            for (int k = 0; k < 3; k++) begin
                kick_at(t);
                last = t;
                t    = t + p;
            end
            run_to(last + 3);
            check(lows == 0, "R3", lows, 0);
            fall_at(last + 3 + SLOW, "R3");
        end

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    // Watchdog on the bench itself
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual %0d expected %0d (run did not finish)", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

endmodule